// File: doc/BRIEF.md
# Outbound Mailbox Channel Dispatcher

This block carries messages from a host to a set of child channels. The host writes a 32-bit word into a small window of the register space. The low four bits of the word name the destination channel. Each channel reports whether it is busy. When the destination is idle, the word goes straight to that channel as a one-cycle strobe that carries the full data word. When the destination is busy, the word waits in a small outbound queue. The queue hands its entries out in arrival order as their channels become free.

A send is discarded in two cases: the queue is already full, or the channel number does not exist. Each discarded send raises a one-cycle error pulse. The host can read a status word that shows whether the queue is full, whether it is empty and how many entries it holds. The child devices themselves and the inbound direction lie outside this block.

Top module: `mbox_out_dispatch`

## Requirements
- R1: A write whose address lies in 0xA0 to 0xAF (upper address nibble 0xA) is a send. Writes to any other address cause no delivery, no queueing and no error pulse.
- R2: The destination channel is wr_data[3:0]. For a send to an idle channel with the queue not full, the matching bit of ch_valid is high for exactly one cycle, on the clock edge that follows the write. ch_data then holds the whole 32-bit word.
- R3: A send to a busy channel, with the queue not full, is stored in the queue and delivers nothing in that cycle. No ch_valid bit rises while that channel's busy input was high in the preceding cycle.
- R4: A send that arrives while the queue is full is discarded, even when its channel is idle. The queue contents stay unchanged.
- R5: A send whose channel number is at or above NCH (default 9) is discarded, and the queue stays unchanged.
- R6: When the queue is not empty and the channel named by the head entry is idle, the head entry is delivered with the same strobe form as in R2 and then removed. At most one entry is delivered per cycle, in arrival order.
- R7: A direct send takes precedence over delivery from the queue. In a cycle with a direct send, the queue head waits and goes out no earlier than the next cycle.
- R8: A head entry whose channel is busy blocks every later entry, even entries whose own channels are idle.
- R9: Reading address 0xB8 returns the queue status: bit 31 is set when the queue is full, bit 30 when it is empty, and bits [7:0] hold the entry count. All other bits read zero. Reads at any other address return zero.
- R10: After reset the queue is empty (status 0x4000_0000), no ch_valid bit is high, drop_err is low, and nothing queued before the reset is ever delivered.
- R11: drop_err is high for exactly one cycle for each discarded send, on the edge that follows the write. The queue depth never exceeds DEPTH (default 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Host write strobe |
| wr_addr | input | 8 | Host write address |
| wr_data | input | 32 | Host write data; bits [3:0] select the channel |
| rd_addr | input | 8 | Host read address |
| rd_data | output | 32 | Read data (queue status at 0xB8), combinational |
| ch_busy | input | NCH | Per-channel busy flags |
| ch_valid | output | NCH | Per-channel one-cycle delivery strobes |
| ch_data | output | 32 | Word delivered with the strobe |
| drop_err | output | 1 | One-cycle pulse for each discarded send |

## Verification
A direct send and the release of a queued head entry can fall in the same cycle, and both then compete for the single delivery slot. The bench provokes this by queueing several words behind a busy channel. In one cycle it then clears that busy flag and sends a word to a different, idle channel. The scoreboard expects the direct word first and the queued words on the following cycles, in arrival order. A separate property forbids two strobes in any one cycle.

// File: rtl/mbox_dispatch_pkg.sv
// Package: shared constants and types for the outbound mailbox dispatcher.
// Assumes a 32-bit message word and an 8-bit host register address.
package mbox_dispatch_pkg;

    localparam int MSG_W      = 32;   // message word width
    localparam int CH_FIELD_W = 4;    // channel tag width in the word
    localparam int REG_AW     = 8;    // host register address width

    localparam logic [REG_AW-1:0] SEND_BASE = 8'hA0;  // send window base
    localparam logic [REG_AW-1:0] STAT_ADDR = 8'hB8;  // queue status

    localparam int STAT_FULL_BIT  = 31;
    localparam int STAT_EMPTY_BIT = 30;
    localparam int STAT_CNT_W     = 8;

    typedef logic [MSG_W-1:0] msg_word_t;

    // What the delivery register takes in a given cycle
    typedef enum logic [1:0] {
        SEL_NONE   = 2'd0,
        SEL_DIRECT = 2'd1,
        SEL_QUEUE  = 2'd2
    } deliver_sel_e;

endpackage

// File: rtl/mbox_send_decode.sv
// Module: mbox_send_decode
// Recognises a host send in the write window and turns the channel tag
// into a one-hot vector. It also reports whether the tag names an existing
// channel and whether that channel is idle.
// Assumes NCH <= 2**CH_FIELD_W. Purely combinational.
module mbox_send_decode
    import mbox_dispatch_pkg::*;
#(
    parameter int NCH = 9
) (
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  msg_word_t         wr_data,
    input  logic [NCH-1:0]    ch_busy,
    output logic              is_send,
    output logic              chan_ok,
    output logic              chan_idle,
    output logic [NCH-1:0]    chan_oh
);

    logic [CH_FIELD_W-1:0] tag;

    // Window match: the upper address bits equal those of the send base
    always_comb begin
        is_send = wr_en && (wr_addr[REG_AW-1:4] == SEND_BASE[REG_AW-1:4]);
    end

    // Tag to one-hot; an out-of-range tag gives an all-zero vector
    always_comb begin
        tag     = wr_data[CH_FIELD_W-1:0];
        chan_oh = '0;
        for (int i = 0; i < NCH; i++) begin
            if (tag == CH_FIELD_W'(i)) begin
                chan_oh[i] = 1'b1;
            end
        end
    end

    // Existence and idle state of the addressed channel
    always_comb begin
        chan_ok   = |chan_oh;
        chan_idle = |(chan_oh & ~ch_busy);
    end

endmodule

// File: rtl/mbox_out_fifo.sv
// Module: mbox_out_fifo
// Circular first-in first-out store for outbound words, with an occupancy
// count. Head data is visible combinationally.
// Assumes the caller never pushes when full or pops when empty. Push and pop
// in the same cycle are allowed. DEPTH >= 2.
module mbox_out_fifo
    import mbox_dispatch_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  msg_word_t        push_data,
    input  logic             pop,
    output msg_word_t        head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);

    localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

    msg_word_t        mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;

    // Storage write; contents need no reset because the count guards them
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Pointer and count update, with wrap for any depth
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
            end
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Head word and occupancy flags
    always_comb begin
        head  = mem[rd_ptr];
        full  = (count == CNT_W'(DEPTH));
        empty = (count == '0);
    end

endmodule

// File: rtl/mbox_route_ctrl.sv
// Module: mbox_route_ctrl
// Chooses, each cycle, between a direct send, delivery from the queue head,
// or nothing. It also decides queue pushes and discards, and registers the
// delivery strobe, the delivered word and the discard pulse.
// Assumes the queue holds only words with valid channel tags.
module mbox_route_ctrl
    import mbox_dispatch_pkg::*;
#(
    parameter int NCH = 9
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           is_send,
    input  logic           chan_ok,
    input  logic           chan_idle,
    input  logic [NCH-1:0] chan_oh,
    input  msg_word_t      wr_data,
    input  logic [NCH-1:0] ch_busy,
    input  logic           q_full,
    input  logic           q_empty,
    input  msg_word_t      q_head,
    output logic           q_push,
    output logic           q_pop,
    output logic [NCH-1:0] ch_valid,
    output msg_word_t      ch_data,
    output logic           drop_err
);

    logic [NCH-1:0] head_oh;
    logic           head_idle;
    logic           accept;
    logic           drop;
    deliver_sel_e   sel;

    // One-hot channel of the queue head
    always_comb begin
        head_oh = '0;
        for (int i = 0; i < NCH; i++) begin
            if (q_head[CH_FIELD_W-1:0] == CH_FIELD_W'(i)) begin
                head_oh[i] = 1'b1;
            end
        end
        head_idle = |(head_oh & ~ch_busy);
    end

    // Send disposition: discard, direct, or queue
    always_comb begin
        accept = is_send && !q_full && chan_ok;
        drop   = is_send && (q_full || !chan_ok);
        q_push = accept && !chan_idle;
    end

    // Delivery slot arbitration: a direct send wins over the queue head
    always_comb begin
        if (accept && chan_idle) begin
            sel = SEL_DIRECT;
        end else if (!q_empty && head_idle) begin
            sel = SEL_QUEUE;
        end else begin
            sel = SEL_NONE;
        end
        q_pop = (sel == SEL_QUEUE);
    end

    // Output registers: strobe, word and discard pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_valid <= '0;
            ch_data  <= '0;
            drop_err <= 1'b0;
        end else begin
            drop_err <= drop;
            unique case (sel)
                SEL_DIRECT: begin
                    ch_valid <= chan_oh;
                    ch_data  <= wr_data;
                end
                SEL_QUEUE: begin
                    ch_valid <= head_oh;
                    ch_data  <= q_head;
                end
                default: begin
                    ch_valid <= '0;
                    ch_data  <= ch_data;
                end
            endcase
        end
    end

endmodule

// File: rtl/mbox_out_dispatch.sv
// Module: mbox_out_dispatch (top)
// Host-to-channel message path. It decodes host sends and routes each word
// directly, or through the outbound queue, by its channel tag. It discards
// sends when the queue is full or the tag is invalid, and exposes the queue
// status for host reads.
// Assumes NCH <= 16, DEPTH <= 255 and a synchronous active-low reset.
module mbox_out_dispatch
    import mbox_dispatch_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int DEPTH = 8,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [MSG_W-1:0]  wr_data,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [MSG_W-1:0]  rd_data,
    input  logic [NCH-1:0]    ch_busy,
    output logic [NCH-1:0]    ch_valid,
    output logic [MSG_W-1:0]  ch_data,
    output logic              drop_err
);

    logic             is_send;
    logic             chan_ok;
    logic             chan_idle;
    logic [NCH-1:0]   chan_oh;
    logic             q_push;
    logic             q_pop;
    msg_word_t        q_head;
    logic [CNT_W-1:0] fifo_cnt;
    logic             fifo_full;
    logic             fifo_empty;
    msg_word_t        stat_word;

    mbox_send_decode #(.NCH(NCH)) u_decode (
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .ch_busy   (ch_busy),
        .is_send   (is_send),
        .chan_ok   (chan_ok),
        .chan_idle (chan_idle),
        .chan_oh   (chan_oh)
    );

    mbox_out_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (q_push),
        .push_data (wr_data),
        .pop       (q_pop),
        .head      (q_head),
        .count     (fifo_cnt),
        .full      (fifo_full),
        .empty     (fifo_empty)
    );

    mbox_route_ctrl #(.NCH(NCH)) u_route (
        .clk       (clk),
        .rst_n     (rst_n),
        .is_send   (is_send),
        .chan_ok   (chan_ok),
        .chan_idle (chan_idle),
        .chan_oh   (chan_oh),
        .wr_data   (wr_data),
        .ch_busy   (ch_busy),
        .q_full    (fifo_full),
        .q_empty   (fifo_empty),
        .q_head    (q_head),
        .q_push    (q_push),
        .q_pop     (q_pop),
        .ch_valid  (ch_valid),
        .ch_data   (ch_data),
        .drop_err  (drop_err)
    );

    // Status word assembly: full, empty and entry count
    always_comb begin
        stat_word                              = '0;
        stat_word[STAT_FULL_BIT]               = fifo_full;
        stat_word[STAT_EMPTY_BIT]              = fifo_empty;
        stat_word[STAT_CNT_W-1:0]              = STAT_CNT_W'(fifo_cnt);
    end

    // Host read mux: only the status address returns data
    always_comb begin
        rd_data = (rd_addr == STAT_ADDR) ? stat_word : '0;
    end

endmodule

// File: rtl/mbox_out_dispatch_chk.sv
// Module: mbox_out_dispatch_chk
// Property checker for the dispatcher, attached by bind. It watches the
// host write port, the channel handshake and the queue occupancy.
module mbox_out_dispatch_chk
    import mbox_dispatch_pkg::*;
#(
    parameter int NCH   = 9,
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [REG_AW-1:0] wr_addr,
    input logic [MSG_W-1:0]  wr_data,
    input logic [NCH-1:0]    ch_busy,
    input logic [NCH-1:0]    ch_valid,
    input logic [MSG_W-1:0]  ch_data,
    input logic              drop_err,
    input logic [CNT_W-1:0]  fifo_cnt,
    input logic              fifo_full
);

    logic           send_seen;
    logic           tag_bad;
    logic           tag_idle;
    logic [NCH-1:0] tag_oh;

    // Independent view of the send and its target, from the ports only
    always_comb begin
        send_seen = wr_en && (wr_addr[7:4] == 4'hA);
        tag_bad   = ({1'b0, wr_data[3:0]} >= 5'(NCH));
        tag_oh    = '0;
        for (int i = 0; i < NCH; i++) begin
            if ({1'b0, wr_data[3:0]} == 5'(i)) begin
                tag_oh[i] = 1'b1;
            end
        end
        tag_idle = |(tag_oh & ~ch_busy);
    end

    // R4: a send into a full queue is discarded
    a_r4_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        send_seen && fifo_full |=> drop_err);

    // R5: an invalid channel tag is discarded
    a_r5_bad_tag_drop: assert property (@(posedge clk) disable iff (!rst_n)
        send_seen && tag_bad |=> drop_err);

    // R2: an accepted send to an idle channel is delivered next cycle
    a_r2_direct_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        send_seen && !fifo_full && !tag_bad && tag_idle
        |=> (ch_valid == $past(tag_oh)) && (ch_data == $past(wr_data)));

    // R3: nothing is delivered to a channel that was busy
    a_r3_no_busy_deliver: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_valid & $past(ch_busy)) == '0);

    // R6: at most one delivery strobe per cycle
    a_r6_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_valid));

    // R11: occupancy never exceeds the depth
    a_r11_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_cnt <= CNT_W'(DEPTH));

    // R1: a write outside the window raises no discard pulse
    a_r1_outside_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !send_seen |=> !drop_err);

endmodule

bind mbox_out_dispatch mbox_out_dispatch_chk #(
    .NCH   (NCH),
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .ch_busy   (ch_busy),
    .ch_valid  (ch_valid),
    .ch_data   (ch_data),
    .drop_err  (drop_err),
    .fifo_cnt  (fifo_cnt),
    .fifo_full (fifo_full)
);

// File: tb/test_mbox_out_dispatch.sv
// Scoreboard bench: the driver pushes expected deliveries into a queue, and
// a monitor pops and compares them as strobes appear.
module test_mbox_out_dispatch;

    localparam int NCH   = 9;
    localparam int DEPTH = 8;
    localparam logic [31:0] ST_EMPTY = 32'h4000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = 8'h00;
    logic [31:0] wr_data = 32'h0;
    logic [7:0]  rd_addr = 8'hB8;
    logic [31:0] rd_data;
    logic [NCH-1:0] ch_busy = '0;
    logic [NCH-1:0] ch_valid;
    logic [31:0] ch_data;
    logic        drop_err;

    int n_tests = 0;
    int n_fail  = 0;
    int drops_seen = 0;
    int exp_drops  = 0;
    bit done = 1'b0;
    string cur_req = "R2";
    int          exp_ch[$];
    logic [31:0] exp_dat[$];
    logic [31:0] held[$];

    always #4 clk = ~clk;

    mbox_out_dispatch #(.NCH(NCH), .DEPTH(DEPTH)) i_mbox_out_dispatch (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ch_busy(ch_busy), .ch_valid(ch_valid), .ch_data(ch_data),
        .drop_err(drop_err)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Monitor: count discard pulses and compare deliveries in order
    always @(negedge clk) begin
        int          idx;
        int          ec;
        logic [31:0] ed;
        if (rst_n) begin
            if (drop_err) drops_seen++;
            if (ch_valid != '0) begin
                idx = -1;
                for (int i = 0; i < NCH; i++) if (ch_valid[i]) idx = i;
                if (exp_ch.size() == 0) begin
                    check(1'b0, cur_req, "unexpected delivery",
                          32'(ch_valid), 32'h0);
                end else begin
                    ec = exp_ch.pop_front();
                    ed = exp_dat.pop_front();
                    check(idx == ec && $countones(ch_valid) == 1,
                          cur_req, "delivery channel", 32'(idx), 32'(ec));
                    check(ch_data == ed, cur_req, "delivery word", ch_data, ed);
                end
            end
        end
    end

    // Driver: one write cycle; a direct send lists its expected delivery
    task automatic send(input logic [7:0] a, input logic [31:0] d,
                        input bit direct);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        if (direct) begin
            exp_ch.push_back(int'(d[3:0]));
            exp_dat.push_back(d);
        end
        @(negedge clk);
        wr_en = 1'b0;
        #1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic expect_status(input logic [31:0] v, input string req);
        rd_addr = 8'hB8; #1;
        check(rd_data == v, req, "status word", rd_data, v);
    endtask

    task automatic expect_drained(input string req);
        check(exp_ch.size() == 0, req, "pending deliveries",
              32'(exp_ch.size()), 32'h0);
        check(drops_seen == exp_drops, req, "discard pulses",
              32'(drops_seen), 32'(exp_drops));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        check(ch_valid == '0 && drop_err == 1'b0, "R10", "outputs in reset",
              {ch_valid, drop_err}, 32'h0);
        rst_n = 1'b1;
        idle(1);
        expect_status(ST_EMPTY, "R10");

        // R2: direct sends across the window
        cur_req = "R2";
        send(8'hA0, 32'h1234_5603, 1'b1);
        send(8'hAC, 32'hCAFE_0000, 1'b1);
        send(8'hA4, 32'h0000_ABC8, 1'b1);
        idle(2);
        expect_drained("R2");
        expect_status(ST_EMPTY, "R2");

        // R1: writes outside the window are ignored
        cur_req = "R1";
        send(8'h90, 32'h0000_0003, 1'b0);
        send(8'hB0, 32'h0000_0001, 1'b0);
        send(8'h9C, 32'h0000_0002, 1'b0);
        idle(3);
        expect_drained("R1");
        expect_status(ST_EMPTY, "R1");

        // R5, R11: invalid channel tags are discarded with one pulse each
        cur_req = "R5";
        send(8'hA0, 32'h5555_0009, 1'b0); exp_drops++;
        send(8'hA8, 32'h5555_000F, 1'b0); exp_drops++;
        idle(3);
        expect_drained("R5");
        expect_status(ST_EMPTY, "R5");

        // R3, R8: queue behind busy channels, head blocks later entries
        cur_req = "R3";
        ch_busy[2] = 1'b1; ch_busy[4] = 1'b1;
        send(8'hA0, 32'hA000_0012, 1'b0);
        send(8'hA0, 32'hA000_0022, 1'b0);
        send(8'hA0, 32'hA000_0032, 1'b0);
        send(8'hA4, 32'hB000_0004, 1'b0);
        expect_status(32'h0000_0004, "R3");
        cur_req = "R8";
        @(negedge clk); ch_busy[4] = 1'b0;
        idle(4);
        expect_drained("R8");
        expect_status(32'h0000_0004, "R8");

        // R7: head release and direct send in the same cycle
        cur_req = "R7";
        @(negedge clk);
        ch_busy[2] = 1'b0;
        wr_en = 1'b1; wr_addr = 8'hA0; wr_data = 32'hD1CE_0005;
        exp_ch.push_back(5); exp_dat.push_back(32'hD1CE_0005);
        exp_ch.push_back(2); exp_dat.push_back(32'hA000_0012);
        exp_ch.push_back(2); exp_dat.push_back(32'hA000_0022);
        exp_ch.push_back(2); exp_dat.push_back(32'hA000_0032);
        exp_ch.push_back(4); exp_dat.push_back(32'hB000_0004);
        @(negedge clk); wr_en = 1'b0;
        idle(6);
        expect_drained("R7");
        expect_status(ST_EMPTY, "R6");

        // R4, R9: fill to the depth, then sends are discarded
        cur_req = "R4";
        ch_busy[1] = 1'b1;
        for (int k = 0; k < DEPTH; k++) begin
            held.push_back(32'h7700_0001 + (32'(k) << 8));
            send(8'hA0, held[k], 1'b0);
        end
        expect_status(32'h8000_0008, "R9");
        send(8'hA0, 32'hDEAD_0006, 1'b0); exp_drops++;
        send(8'hA0, 32'hDEAD_0001, 1'b0); exp_drops++;
        idle(2);
        expect_drained("R4");
        expect_status(32'h8000_0008, "R4");
        rd_addr = 8'h98; #1;
        check(rd_data == 32'h0, "R9", "read at other address", rd_data, 32'h0);

        // R6: queued entries drain in arrival order
        cur_req = "R6";
        @(negedge clk);
        ch_busy[1] = 1'b0;
        for (int k = 0; k < DEPTH; k++) begin
            exp_ch.push_back(1); exp_dat.push_back(held[k]);
        end
        idle(DEPTH + 3);
        expect_drained("R6");
        expect_status(ST_EMPTY, "R6");

        // R10: reset empties the queue; nothing queued is delivered later
        cur_req = "R10";
        ch_busy[3] = 1'b1;
        send(8'hA0, 32'h0BAD_0003, 1'b0);
        send(8'hA0, 32'h0BAD_1003, 1'b0);
        expect_status(32'h0000_0002, "R10");
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        idle(1);
        expect_status(ST_EMPTY, "R10");
        ch_busy[3] = 1'b0;
        idle(4);
        expect_drained("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule